// File: doc/BRIEF.md
# Bus Slave Responder with Power-Up Sequencer

This block is a minimal slave and system-control unit for a processor on an asynchronous, multiplexed, active-low address/data bus. After reset it holds the processor's two power-good lines low and then releases them in turn. The DC-good line is released first, and the AC-good line follows after a fixed number of clocks. Once the processor runs, the block acknowledges each address phase and captures the address. It answers every read or write strobe with an immediate reply.

On any read the block drives a fixed no-operation instruction word, so the processor steps through memory like a counter. A sticky flag records when the captured address reaches a chosen target, so a bench or a board can see that the processor has run far enough. A second sticky flag records any cycle in which the read and write strobes are both active.

Top module: `bus_stub_top`

## Requirements
- R1: While `rst_n` is low, `dclo_n` and `aclo_n` are both low. `dclo_n` goes high after the 5th rising clock edge that follows reset release (parameter `DC_CLKS`).
- R2: `aclo_n` goes high after the 10th rising edge that follows the edge which raised `dclo_n` (parameter `AC_CLKS`), so 15 edges after reset release by default. It is never high while `dclo_n` is low.
- R3: `ar_n` is low exactly when `sync_n` is low now and was also low at the previous rising edge. It therefore asserts one edge after SYNC, once the address is held, and it falls back combinationally when `sync_n` rises.
- R4: At the first rising edge at which `sync_n` is seen low, `addr_q` loads the bitwise inverse of `ad_i`, because the bus lines are active-low. `addr_q` keeps that value until the next such edge.
- R5: `rply_n` is low, combinationally and with no wait cycles, exactly when `sync_n` is low, `iako_n` is high, and `din_n` or `dout_n` is low.
- R6: `ad_oe` is high exactly when `din_n` is low and `iako_n` is high. This includes the start-vector read with `sync_n` high. `ad_oe` falls in the same cycle that `din_n` rises. `ad_o` always carries the line-level inverse of octal 000240, which is 16'hFF5F.
- R7: While `iako_n` is low, the block gives no reply and no drive: `rply_n` stays high and `ad_oe` stays low.
- R8: `selftest_pass` goes high at the capture edge that loads hex 00FE (parameter `PASS_ADDR`) into `addr_q`. It then stays high until reset.
- R9: At any rising edge where `din_n` and `dout_n` are both low, `proto_err` becomes high and stays high until reset. During such a cycle `rply_n` still follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Address-phase strobe, active low |
| din_n | input | 1 | Read strobe, active low |
| dout_n | input | 1 | Write strobe, active low |
| iako_n | input | 1 | Interrupt-acknowledge output of the processor, active low |
| ad_i | input | 16 | Address/data lines as seen, active low |
| ad_o | output | 16 | Line levels driven during reads (no-op word) |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| rply_n | output | 1 | Reply, active low |
| ar_n | output | 1 | Address acknowledge, active low |
| dclo_n | output | 1 | DC power-good to processor, low = hold |
| aclo_n | output | 1 | AC power-good to processor, low = hold |
| addr_q | output | 16 | Last captured address, logic polarity |
| selftest_pass | output | 1 | Sticky: target address was reached |
| proto_err | output | 1 | Sticky: read and write strobes active together |

## Verification
Address capture and reply can happen in the same cycle. When `sync_n` and `din_n` fall together, the edge that loads `addr_q` is also the edge where `rply_n` and `ad_oe` are already low, while `ar_n` only asserts one edge later. The bench provokes this by dropping both strobes in one step. The bench's reference model, compared on every clock, judges each output in that cycle and the next, together with the normal case where the read strobe follows the address phase. The same approach covers a collision of both strobes inside an address phase: the reply must stay asserted while the error flag sets.

// File: rtl/bus_stub_pkg.sv
package bus_stub_pkg;
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_DCUP = 2'd1,
    PH_RUN  = 2'd2
  } pwr_phase_t;

  localparam logic [15:0] NOP_WORD = 16'h00A0;
endpackage

// File: rtl/bus_stub_pwrseq.sv
module bus_stub_pwrseq
  import bus_stub_pkg::*;
#(
  parameter int DC_CLKS = 5,
  parameter int AC_CLKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic dclo_n,
  output logic aclo_n
);
  localparam int MAXC = (DC_CLKS > AC_CLKS) ? DC_CLKS : AC_CLKS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DC_LAST = CW'(DC_CLKS - 1);
  localparam logic [CW-1:0] AC_LAST = CW'(AC_CLKS - 1);

  pwr_phase_t    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (ph_q)
      PH_HOLD: begin
        cnt_en = 1'b1;
        if (cnt_q == DC_LAST) begin
          ph_d  = PH_DCUP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DCUP: begin
        cnt_en = 1'b1;
        if (cnt_q == AC_LAST) begin
          ph_d  = PH_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_HOLD;
      cnt_q <= '0;
    end else if (cnt_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign dclo_n = (ph_q != PH_HOLD);
  assign aclo_n = (ph_q == PH_RUN);
endmodule

// File: rtl/bus_stub_addr.sv
module bus_stub_addr #(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] PASS_ADDR = 16'h00FE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_act,
  input  logic [AW-1:0] ad_i,
  output logic          sync_seen,
  output logic [AW-1:0] addr_q,
  output logic          pass_q
);
  logic          cap_en;
  logic [AW-1:0] addr_d;
  logic          pass_d;

  always_comb begin
    cap_en = sync_act && !sync_seen;
    addr_d = ~ad_i;
    pass_d = pass_q || (addr_d == PASS_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_seen <= 1'b0;
    else        sync_seen <= sync_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pass_q <= 1'b0;
    end else if (cap_en) begin
      addr_q <= addr_d;
      pass_q <= pass_d;
    end
  end
endmodule

// File: rtl/bus_stub_resp.sv
module bus_stub_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_act,
  input  logic sync_seen,
  input  logic rd_act,
  input  logic wr_act,
  input  logic iak_act,
  output logic reply,
  output logic addr_ack,
  output logic drive,
  output logic err_q
);
  logic err_d, err_en;

  always_comb begin
    reply    = sync_act && !iak_act && (rd_act || wr_act);
    addr_ack = sync_act && sync_seen;
    drive    = rd_act && !iak_act;
    err_en   = rd_act && wr_act;
    err_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end
endmodule

// File: rtl/bus_stub_top.sv
module bus_stub_top
  import bus_stub_pkg::*;
#(
  parameter int          DC_CLKS   = 5,
  parameter int          AC_CLKS   = 10,
  parameter logic [15:0] PASS_ADDR = 16'h00FE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_n,
  input  logic        din_n,
  input  logic        dout_n,
  input  logic        iako_n,
  input  logic [15:0] ad_i,
  output logic [15:0] ad_o,
  output logic        ad_oe,
  output logic        rply_n,
  output logic        ar_n,
  output logic        dclo_n,
  output logic        aclo_n,
  output logic [15:0] addr_q,
  output logic        selftest_pass,
  output logic        proto_err
);
  logic sync_seen, reply, addr_ack;

  bus_stub_pwrseq #(.DC_CLKS(DC_CLKS), .AC_CLKS(AC_CLKS)) u_pwr (
    .clk(clk), .rst_n(rst_n), .dclo_n(dclo_n), .aclo_n(aclo_n)
  );

  bus_stub_addr #(.AW(16), .PASS_ADDR(PASS_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .sync_act(!sync_n), .ad_i(ad_i),
    .sync_seen(sync_seen), .addr_q(addr_q), .pass_q(selftest_pass)
  );

  bus_stub_resp u_resp (
    .clk(clk), .rst_n(rst_n), .sync_act(!sync_n), .sync_seen(sync_seen),
    .rd_act(!din_n), .wr_act(!dout_n), .iak_act(!iako_n),
    .reply(reply), .addr_ack(addr_ack), .drive(ad_oe), .err_q(proto_err)
  );

  assign rply_n = !reply;
  assign ar_n   = !addr_ack;
  assign ad_o   = ~NOP_WORD;
endmodule

// File: rtl/bus_stub_chk.sv
module bus_stub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sync_n,
  input logic        din_n,
  input logic        dout_n,
  input logic        iako_n,
  input logic        ad_oe,
  input logic        rply_n,
  input logic        ar_n,
  input logic        dclo_n,
  input logic        aclo_n,
  input logic [15:0] addr_q,
  input logic        selftest_pass,
  input logic        proto_err
);
  // R1
  dclo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclo_n |=> dclo_n);
  // R2
  aclo_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aclo_n |-> dclo_n);
  // R3
  ar_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ar_n |-> (!sync_n && !$past(sync_n)));
  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |=> $stable(addr_q));
  // R5
  rply_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rply_n |-> (!sync_n && iako_n && (!din_n || !dout_n)));
  // R6
  oe_needs_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !din_n);
  // R7
  iak_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iako_n |-> (rply_n && !ad_oe));
  // R8
  pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    selftest_pass |=> selftest_pass);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind bus_stub_top bus_stub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .din_n(din_n), .dout_n(dout_n),
  .iako_n(iako_n), .ad_oe(ad_oe), .rply_n(rply_n), .ar_n(ar_n),
  .dclo_n(dclo_n), .aclo_n(aclo_n), .addr_q(addr_q),
  .selftest_pass(selftest_pass), .proto_err(proto_err)
);

// File: tb/bus_stub_top_test.sv
module bus_stub_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b1, din_n = 1'b1, dout_n = 1'b1, iako_n = 1'b1;
  logic [15:0] ad_i = 16'hFFFF;
  logic [15:0] ad_o, addr_q;
  logic        ad_oe, rply_n, ar_n, dclo_n, aclo_n, selftest_pass, proto_err;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  // reference model state
  int          m_edges;
  bit          m_sync_prev, m_pass, m_err;
  logic [15:0] m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_stub_top uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .din_n(din_n), .dout_n(dout_n),
    .iako_n(iako_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .rply_n(rply_n),
    .ar_n(ar_n), .dclo_n(dclo_n), .aclo_n(aclo_n), .addr_q(addr_q),
    .selftest_pass(selftest_pass), .proto_err(proto_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges = 0; m_sync_prev = 0; m_pass = 0; m_err = 0; m_addr = '0;
    end else begin
      if (m_edges < 1000) m_edges++;
      if (!sync_n && !m_sync_prev) begin
        m_addr = ~ad_i;
        if (m_addr == 16'h00FE) m_pass = 1;
      end
      if (!din_n && !dout_n) m_err = 1;
      m_sync_prev = !sync_n;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R1 dclo_n", 16'(dclo_n), 16'(rst_n && m_edges >= 5));
      chk("R2 aclo_n", 16'(aclo_n), 16'(rst_n && m_edges >= 15));
      chk("R3 ar_n", 16'(ar_n), 16'(!(!sync_n && m_sync_prev)));
      chk("R4 addr_q", addr_q, m_addr);
      chk("R5 R7 rply_n", 16'(rply_n), 16'(!(!sync_n && iako_n && (!din_n || !dout_n))));
      chk("R6 R7 ad_oe", 16'(ad_oe), 16'(!din_n && iako_n));
      chk("R6 ad_o", ad_o, 16'hFF5F);
      chk("R8 selftest_pass", 16'(selftest_pass), 16'(m_pass));
      chk("R9 proto_err", 16'(proto_err), 16'(m_err));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input logic s, input logic d, input logic o, input logic i,
                      input logic [15:0] a);
    @(negedge clk);
    #1;
    sync_n = s; din_n = d; dout_n = o; iako_n = i; ad_i = a;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1, 1, 1, 1, 16'hFFFF);
  endtask

  task automatic rd_cycle(input logic [15:0] addr);
    step(0, 1, 1, 1, ~addr);
    step(0, 0, 1, 1, 16'hFFFF);
    step(0, 0, 1, 1, 16'hFFFF);
    step(1, 1, 1, 1, 16'hFFFF);
  endtask

  task automatic wr_cycle(input logic [15:0] addr);
    step(0, 1, 1, 1, ~addr);
    step(0, 1, 0, 1, 16'h1234);
    step(1, 1, 1, 1, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 R2: power-good sequence observed by per-clock compare
    idle(20);
    // R6: start-vector read, DIN without SYNC: drive, no reply
    step(1, 0, 1, 1, 16'hFFFF);
    step(1, 0, 1, 1, 16'hFFFF);
    idle(1);
    // R3 R4 R5: address phase then read, and then a write
    rd_cycle(16'h0000);
    rd_cycle(16'h0002);
    wr_cycle(16'h0BEE);
    // R3 R4 R5 R6: SYNC and DIN fall in the same cycle
    step(0, 0, 1, 1, ~16'h0A3A);
    step(0, 0, 1, 1, 16'hFFFF);
    step(1, 1, 1, 1, 16'hFFFF);
    // R7: interrupt acknowledge gets no reply and no drive
    step(0, 1, 1, 0, ~16'h0100);
    step(0, 0, 1, 0, 16'hFFFF);
    step(1, 1, 1, 1, 16'hFFFF);
    // R8: counter-like sweep up to the pass address
    for (int a = 4; a <= 16'h0100; a += 2) rd_cycle(16'(a));
    @(negedge clk);
    chk("R8 pass after sweep", 16'(selftest_pass), 16'h1);
    // R9: both strobes inside SYNC, reply still asserted
    step(0, 1, 1, 1, ~16'h0200);
    step(0, 0, 0, 1, 16'hFFFF);
    @(negedge clk);
    chk("R9 rply during collision", 16'(rply_n), 16'h0);
    step(1, 1, 1, 1, 16'hFFFF);
    idle(2);
    chk("R9 err sticky", 16'(proto_err), 16'h1);
    chk("R4 addr held", addr_q, 16'h0200);
    // R1: reset state again
    @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset dclo_n", 16'(dclo_n), 16'h0);
    chk("R2 reset aclo_n", 16'(aclo_n), 16'h0);
    chk("R8 reset pass", 16'(selftest_pass), 16'h0);
    #1 rst_n = 1'b1;
    idle(17);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule